// File: doc/BRIEF.md
# Frame-Locked Sample-Rate Prescaler with Standby Control

This block sits beside a voiceband codec core and turns a 2.000 MHz master clock into two single-cycle enables: a 256 kHz enable for the converter logic and an 8 kHz sample enable. The 256 kHz rate is not an integer divide of the master clock (2000/256 = 7.8125). It is made by a phase accumulator that advances by 32 modulo 250 on every master cycle, which gives exactly 32 fast enables in each 250-cycle frame. Both enables restart on every rising edge of the external frame sync, so the sample instant follows the serial port's framing.

Each rise-to-rise interval is counted in master cycles and compared with the nominal 250. An interval outside the tolerance sets a sticky lock-error flag. While the flag is set, the enables run on at the nominal ratio and ignore frame sync for phase. The block also owns the power state. A low power-up pin forces power-down. A frame sync that stays low for a whole frame period drops the block into standby. A frame-sync rise with the pin high brings it back to active. After each entry into active, a guard of two further frame-sync rises must pass before the serial transmit output may leave high impedance.

Top module: `fs_prescaler`

## Requirements
- R1: After reset, pwr_state is STANDBY (2'b10), tick_256k, tick_8k, port_en and lock_err are all 0. A reset also clears a set lock_err.
- R2: With frame-sync rises every 250 master cycles, exactly 32 tick_256k pulses and exactly one tick_8k pulse occur per frame, and every tick_8k pulse coincides with a tick_256k pulse.
- R3: When fsync is high at a clock edge after being low at the previous edge, tick_8k (and tick_256k) is high in the cycle that follows the next edge, and the fast-rate phase restarts from there.
- R4: With no frame-sync rise, tick_8k repeats every 250 master cycles, so a 252-cycle frame shows two tick_8k pulses.
- R5: In ACTIVE, a rise-to-rise interval P measured after an earlier rise in ACTIVE sets lock_err when P > 252 or P < 248. Intervals of 248 and 252 do not set it. lock_err stays set until reset.
- R6: While lock_err is set, frame-sync rises do not restart the enables: any 1000 consecutive cycles hold exactly 4 tick_8k and 128 tick_256k pulses.
- R7: In ACTIVE, 250 consecutive cycles of fsync low (as seen after its two input registers) move pwr_state to STANDBY. If a frame-sync rise falls in the cycle that reaches the limit, the rise wins and the block stays ACTIVE.
- R8: From STANDBY or POWERDOWN, a frame-sync rise with pwr_up high moves pwr_state to ACTIVE (2'b01). With pwr_up high but fsync held low, POWERDOWN is kept.
- R9: pwr_up low for two consecutive cycles forces pwr_state to POWERDOWN (2'b00) from any state. Outside ACTIVE, both tick outputs stay 0.
- R10: port_en is high only in ACTIVE and only after two frame-sync rises that follow the rise of entry into ACTIVE. Each new entry into ACTIVE restarts the guard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (2.000 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | External 8 kHz frame sync |
| pwr_up | input | 1 | Power-up pin; low forces power-down |
| tick_256k | output | 1 | Single-cycle 256 kHz enable |
| tick_8k | output | 1 | Single-cycle 8 kHz sample enable, frame aligned |
| pwr_state | output | 2 | 01 ACTIVE, 10 STANDBY, 00 POWERDOWN |
| port_en | output | 1 | Transmit output may leave high impedance |
| lock_err | output | 1 | Sticky frame-length error |

## Verification
The collision to watch is a frame-sync rise in the same cycle as the standby timeout. This happens when the sync stays low for exactly the limit, so the idle counter reaches its end just as the delayed sync edge shows up. The bench shapes one-cycle sync pulses with a 250-cycle low gap, which makes the two events meet, and then a 251-cycle gap, which makes the timeout win one cycle earlier. It judges the outcome at the ports. After the meeting, port_en stays high because the rise kept the block ACTIVE. After the earlier timeout, port_en falls because the following rise counts as a fresh entry and the guard restarts.

// File: rtl/fs_prescaler_pkg.sv
`timescale 1ns/1ps
package fs_prescaler_pkg;

    typedef enum logic [1:0] {
        PS_DOWN    = 2'b00,
        PS_ACTIVE  = 2'b01,
        PS_STANDBY = 2'b10
    } pstate_e;

    typedef struct packed {
        logic fs1;
        logic fs2;
        logic pu;
    } edge_regs_t;

endpackage

// File: rtl/fps_edge.sv
`timescale 1ns/1ps
module fps_edge
    import fs_prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic pwr_up,
    output logic rise,
    output logic fs_low,
    output logic pu
);
    edge_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.fs1 = fsync;
        r_d.fs2 = r_q.fs1;
        r_d.pu  = pwr_up;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.fs1 <= 1'b0;
            r_q.fs2 <= 1'b0;
            r_q.pu  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rise   = r_q.fs1 & ~r_q.fs2;
    assign fs_low = ~r_q.fs2;
    assign pu     = r_q.pu;
endmodule

// File: rtl/fps_meter.sv
`timescale 1ns/1ps
module fps_meter #(
    parameter int FRAME_CYC = 250,
    parameter int LOCK_TOL  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic fs_low,
    input  logic active,
    output logic lock_err,
    output logic timeout
);
    localparam int CW = $clog2(FRAME_CYC * 4);
    localparam int IW = $clog2(FRAME_CYC);
    localparam logic [CW-1:0] PER_HI   = CW'(FRAME_CYC + LOCK_TOL);
    localparam logic [CW-1:0] PER_LO   = CW'(FRAME_CYC - LOCK_TOL);
    localparam logic [CW-1:0] CYC_SAT  = CW'((1 << CW) - 2);
    localparam logic [IW-1:0] IDLE_LIM = IW'(FRAME_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [IW-1:0] idle;
        logic          ref_ok;
        logic          err;
    } meter_t;

    meter_t r_q, r_d;
    logic [CW-1:0] period;

    always_comb begin
        r_d    = r_q;
        period = r_q.cyc + 1'b1;
        if (rise) begin
            r_d.cyc    = '0;
            r_d.ref_ok = 1'b1;
            if (active && r_q.ref_ok && ((period > PER_HI) || (period < PER_LO)))
                r_d.err = 1'b1;
        end else begin
            if (r_q.cyc != CYC_SAT)
                r_d.cyc = r_q.cyc + 1'b1;
            if (!active)
                r_d.ref_ok = 1'b0;
        end
        if (!fs_low)
            r_d.idle = '0;
        else if (r_q.idle != IDLE_LIM)
            r_d.idle = r_q.idle + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lock_err = r_q.err;
    assign timeout  = fs_low && (r_q.idle == IDLE_LIM);
endmodule

// File: rtl/fps_rate.sv
`timescale 1ns/1ps
module fps_rate #(
    parameter int FRAME_CYC = 250,
    parameter int TICKS     = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick_fast,
    output logic tick_frame
);
    localparam int PW = $clog2(FRAME_CYC);
    localparam int AW = $clog2(FRAME_CYC + TICKS);
    localparam logic [PW-1:0] POS_LAST = PW'(FRAME_CYC - 1);
    localparam logic [AW-1:0] MODULUS  = AW'(FRAME_CYC);
    localparam logic [AW-1:0] STEP     = AW'(TICKS);

    typedef struct packed {
        logic [PW-1:0] pos;
        logic [AW-1:0] acc;
        logic          fast;
        logic          frame;
    } rate_t;

    rate_t r_q, r_d;
    logic [AW-1:0] sum;

    always_comb begin
        r_d       = r_q;
        r_d.fast  = 1'b0;
        r_d.frame = 1'b0;
        sum       = r_q.acc + STEP;
        if (!run) begin
            r_d.pos = '0;
            r_d.acc = '0;
        end else if (restart || (r_q.pos == POS_LAST)) begin
            r_d.pos   = '0;
            r_d.acc   = '0;
            r_d.fast  = 1'b1;
            r_d.frame = 1'b1;
        end else begin
            r_d.pos = r_q.pos + 1'b1;
            if (sum >= MODULUS) begin
                r_d.acc  = sum - MODULUS;
                r_d.fast = 1'b1;
            end else begin
                r_d.acc  = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick_fast  = r_q.fast;
    assign tick_frame = r_q.frame;
endmodule

// File: rtl/fps_power.sv
`timescale 1ns/1ps
module fps_power
    import fs_prescaler_pkg::*;
#(
    parameter int GUARD_FRAMES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rise,
    input  logic    pu,
    input  logic    timeout,
    output pstate_e state,
    output logic    active_q,
    output logic    active_d,
    output logic    entering,
    output logic    port_en
);
    localparam int FW = $clog2(GUARD_FRAMES + 1);
    localparam logic [FW-1:0] GUARD_V = FW'(GUARD_FRAMES);

    typedef struct packed {
        pstate_e       st;
        logic [FW-1:0] fc;
    } pwr_t;

    pwr_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        entering = 1'b0;
        if (!pu) begin
            r_d.st = PS_DOWN;
        end else begin
            case (r_q.st)
                PS_ACTIVE: begin
                    if (timeout && !rise)
                        r_d.st = PS_STANDBY;
                    else if (rise && (r_q.fc != GUARD_V))
                        r_d.fc = r_q.fc + 1'b1;
                end
                default: begin
                    if (rise) begin
                        r_d.st   = PS_ACTIVE;
                        r_d.fc   = '0;
                        entering = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= PS_STANDBY;
            r_q.fc <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state    = r_q.st;
    assign active_q = (r_q.st == PS_ACTIVE);
    assign active_d = (r_d.st == PS_ACTIVE);
    assign port_en  = (r_q.st == PS_ACTIVE) && (r_q.fc == GUARD_V);
endmodule

// File: rtl/fs_prescaler.sv
`timescale 1ns/1ps
module fs_prescaler
    import fs_prescaler_pkg::*;
#(
    parameter int FRAME_CYC       = 250,
    parameter int TICKS_PER_FRAME = 32,
    parameter int LOCK_TOL        = 2,
    parameter int GUARD_FRAMES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fsync,
    input  logic       pwr_up,
    output logic       tick_256k,
    output logic       tick_8k,
    output logic [1:0] pwr_state,
    output logic       port_en,
    output logic       lock_err
);
    logic    rise, fs_low, pu, timeout;
    logic    active_q, active_d, entering, restart;
    pstate_e state;

    fps_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .fsync  (fsync),
        .pwr_up (pwr_up),
        .rise   (rise),
        .fs_low (fs_low),
        .pu     (pu)
    );

    fps_meter #(.FRAME_CYC(FRAME_CYC), .LOCK_TOL(LOCK_TOL)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fs_low   (fs_low),
        .active   (active_q),
        .lock_err (lock_err),
        .timeout  (timeout)
    );

    fps_power #(.GUARD_FRAMES(GUARD_FRAMES)) u_power (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .pu       (pu),
        .timeout  (timeout),
        .state    (state),
        .active_q (active_q),
        .active_d (active_d),
        .entering (entering),
        .port_en  (port_en)
    );

    // A rise restarts the enables on entry, or in ACTIVE while still locked.
    assign restart = rise && (entering || (active_q && !lock_err));

    fps_rate #(.FRAME_CYC(FRAME_CYC), .TICKS(TICKS_PER_FRAME)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (active_d),
        .restart    (restart),
        .tick_fast  (tick_256k),
        .tick_frame (tick_8k)
    );

    assign pwr_state = state;
endmodule

// File: rtl/fs_prescaler_chk.sv
`timescale 1ns/1ps
module fs_prescaler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_up,
    input logic       tick_256k,
    input logic       tick_8k,
    input logic [1:0] pwr_state,
    input logic       port_en,
    input logic       lock_err
);
    // R2
    frame_tick_on_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_8k |-> tick_256k);

    // R5
    lock_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> lock_err);

    // R9
    ticks_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'b01) |-> (!tick_256k && !tick_8k));

    // R9
    pin_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_up && $past(!pwr_up) && $past(rst_n)) |=> (pwr_state == 2'b00));

    // R10
    port_en_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> (pwr_state == 2'b01));
endmodule

bind fs_prescaler fs_prescaler_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_up    (pwr_up),
    .tick_256k (tick_256k),
    .tick_8k   (tick_8k),
    .pwr_state (pwr_state),
    .port_en   (port_en),
    .lock_err  (lock_err)
);

// File: tb/fs_prescaler_bench.sv
`timescale 1ns/1ps
module fs_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst_n, fsync, pwr_up;
    logic       tick_256k, tick_8k, port_en, lock_err;
    logic [1:0] pwr_state;

    int n_tests = 0;
    int n_fail  = 0;
    int cnt_f   = 0;
    int cnt_s   = 0;

    typedef struct {
        string req;
        int    exp;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    fs_prescaler u_fs_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .pwr_up    (pwr_up),
        .tick_256k (tick_256k),
        .tick_8k   (tick_8k),
        .pwr_state (pwr_state),
        .port_en   (port_en),
        .lock_err  (lock_err)
    );

    // Tick counting monitor: samples 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (tick_256k) cnt_f++;
        if (tick_8k)   cnt_s++;
    end

    task automatic push_exp(input string req, input int exp);
        sb_q.push_back('{req: req, exp: exp});
    endtask

    task automatic pop_cmp(input int act);
        exp_t e;
        e = sb_q.pop_front();
        n_tests++;
        if (act != e.exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", e.req, act, e.exp);
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        push_exp(req, exp);
        pop_cmp(act);
    endtask

    task automatic frame(input int p, input int h);
        for (int i = 0; i < p; i++) begin
            fsync = (i < h);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int f0, s0;
        fsync  = 1'b0;
        pwr_up = 1'b1;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 state", pwr_state, 2);
        check("R1 ticks", cnt_f + cnt_s, 0);
        check("R1 port_en", port_en, 0);
        check("R1 lock_err", lock_err, 0);

        // R3 / R8 entry and phase of the sample enable
        fsync = 1'b1;
        @(negedge clk);
        check("R3 tick_8k one edge after sample", tick_8k, 0);
        @(negedge clk);
        check("R3 tick_8k two edges after sample", tick_8k, 1);
        check("R8 entry to ACTIVE", pwr_state, 1);
        @(negedge clk);
        @(negedge clk);
        fsync = 1'b0;
        repeat (246) @(negedge clk);

        // R2 steady frame counts, R10 guard
        f0 = cnt_f; s0 = cnt_s;
        frame(250, 4);
        check("R2 fast ticks per frame", cnt_f - f0, 32);
        check("R2 frame ticks per frame", cnt_s - s0, 1);
        check("R10 port_en after one rise", port_en, 0);
        frame(250, 4);
        check("R10 port_en after two rises", port_en, 1);

        // R3 re-phase on a short frame, R4 free run on a long one
        s0 = cnt_s;
        frame(248, 4);
        check("R3 short frame one tick", cnt_s - s0, 1);
        s0 = cnt_s;
        frame(252, 4);
        check("R4 free-run tick in long frame", cnt_s - s0, 2);
        frame(250, 4);
        check("R5 intervals 248 and 252 accepted", lock_err, 0);

        // R7 collision: rise in the timeout cycle wins
        frame(250, 1);
        frame(251, 1);
        frame(250, 1);
        check("R7 collision stays ACTIVE", pwr_state, 1);
        check("R7 collision keeps port_en", port_en, 1);
        frame(252, 1);
        frame(250, 1);
        check("R7 early timeout re-entry state", pwr_state, 1);
        check("R7 early timeout restarts guard", port_en, 0);

        // R7 standby on missing sync, R9 ticks gated
        repeat (300) @(negedge clk);
        check("R7 standby state", pwr_state, 2);
        check("R10 port_en in standby", port_en, 0);
        f0 = cnt_f;
        repeat (100) @(negedge clk);
        check("R9 no ticks in standby", cnt_f - f0, 0);

        // R8 re-entry, R10 guard
        frame(250, 4);
        check("R8 standby to ACTIVE", pwr_state, 1);
        frame(250, 4);
        check("R10 guard after re-entry", port_en, 0);
        frame(250, 4);
        check("R10 port_en after re-entry", port_en, 1);

        // R9 power-down
        pwr_up = 1'b0;
        repeat (5) @(negedge clk);
        f0 = cnt_f; s0 = cnt_s;
        frame(250, 4);
        frame(250, 4);
        check("R9 powerdown state", pwr_state, 0);
        check("R9 no ticks in powerdown", (cnt_f - f0) + (cnt_s - s0), 0);
        check("R10 port_en in powerdown", port_en, 0);
        pwr_up = 1'b1;
        repeat (300) @(negedge clk);
        check("R8 no sync keeps powerdown", pwr_state, 0);
        frame(250, 4);
        check("R8 powerdown to ACTIVE", pwr_state, 1);

        // R5 lock error boundary
        frame(250, 4);
        frame(253, 4);
        check("R5 not yet measured", lock_err, 0);
        frame(250, 4);
        check("R5 interval 253 sets lock_err", lock_err, 1);

        // R6 free run while unlocked
        f0 = cnt_f; s0 = cnt_s;
        for (int k = 0; k < 5; k++) frame(200, 4);
        check("R6 frame ticks in 1000 cycles", cnt_s - s0, 4);
        check("R6 fast ticks in 1000 cycles", cnt_f - f0, 128);
        check("R5 lock_err sticky", lock_err, 1);

        // R1 reset clears the flag
        do_reset();
        check("R1 reset clears lock_err", lock_err, 0);
        check("R1 reset state again", pwr_state, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule